// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects up to eight interrupt requests, latches each one on its rising edge, filters them through a software mask and picks a winner under one of four priority schemes. The winner is offered to the processor as a single request line together with a vector. The vector is the programmed base plus the level number. When the processor takes the vector, the level leaves the pending set and enters the in-service set. It stays there until software issues an end-of-interrupt command.

Software reaches the block through a small write port with four registers:

| Address | Register |
|---|---|
| 0 | mask byte |
| 1 | mode |
| 2 | command |
| 3 | vector base |

The command register takes an opcode in bits [7:5] and a level in bits [2:0]:

| Opcode | Command |
|---|---|
| 001 | end-of-interrupt for the highest in-service level |
| 010 | set the lowest-priority level |
| 011 | end-of-interrupt for the named level |

The mode field in bits [1:0] selects the priority scheme:

| Value | Mode |
|---|---|
| 0 | fixed |
| 1 | rotate on end-of-interrupt |
| 2 | software-specified lowest |
| 3 | polled |

Any write takes effect at the next clock edge, so the mode and the priority assignment can change at any time.

The vector leaves on a valid/ready pair. The transfer happens on a cycle where `intr_valid` and `intr_ready` are both high. Holding `intr_ready` low stalls nothing inside the block: requests keep latching, and the offered vector may change to a higher-priority level or drop away after a mask write before it is taken. `intr_ready` while `intr_valid` is low has no effect.

In polled mode the request line stays low. Software reads `poll_data` instead and pulses `poll_rd` to take the reported level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask is 0x00, the mode is fixed (0), the lowest-priority level is 7, the vector base is 0x00, and no request is pending or in service. As a result `intr_valid` is 0, `in_service` is 0x00 and `poll_data` is 0x00.
- R2: A request bit is latched on a rising edge of its `req_i` line. It stays pending after the line falls, until its level is taken.
- R3: A masked level (mask bit 1, mask at address 0) is never offered. It stays latched and is offered once its mask bit is cleared.
- R4: In fixed mode (mode 0) level 0 has the highest priority and level 7 the lowest.
- R5: A transfer (`intr_valid` and `intr_ready` high) returns `intr_vector` = base + level. The level moves from pending to in service. `intr_ready` alone changes nothing.
- R6: A pending level is offered only if it has higher priority than every level currently in service.
- R7: Command opcode 001 clears the in-service bit of the highest-priority in-service level.
- R8: In rotate mode (mode 1), opcode 001 also makes the cleared level the lowest priority. The next level up becomes the highest.
- R9: Opcode 010 sets the lowest-priority level to bits [2:0]. In modes 1, 2 and 3 the levels then rank upward in numeric order from the one above it, wrapping after 7.
- R10: In polled mode (mode 3) `intr_valid` stays 0. `poll_data` is {found, 0000, level} for the highest-priority unmasked pending level. A `poll_rd` pulse moves that level into service.
- R11: Command opcode 011 clears the in-service bit of the level in bits [2:0].
- R12: A mode write takes effect on the next cycle and re-ranks the levels already pending. Fixed mode ignores the stored lowest level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Interrupt request lines, rising edge latched |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| intr_valid | output | 1 | Interrupt request / vector valid |
| intr_ready | input | 1 | Processor acknowledge |
| intr_vector | output | 8 | Vector of the offered level |
| poll_rd | input | 1 | Polled-mode take strobe |
| poll_data | output | 8 | Encoded highest pending level |
| in_service | output | 8 | In-service set |

## Verification
The bench builds the block with its defaults: eight levels and an eight-bit data path. With those values every wrap of the rotating priority pointer is reachable. The table checks the fixed order for mask and request patterns that include an empty result and a fully masked one. Directed cases then nest two levels, retire them in both end-of-interrupt forms, move the lowest level by rotation and by command, and switch modes while requests are pending, so that the same pending set is resolved two ways.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED    = 2'd0,
    MODE_ROTATE   = 2'd1,
    MODE_SPECIFIC = 2'd2,
    MODE_POLL     = 2'd3
  } irq_mode_e;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;
  localparam logic [1:0] ADDR_BASE = 2'd3;

  localparam logic [2:0] OP_EOI_TOP  = 3'b001;
  localparam logic [2:0] OP_SET_LOW  = 3'b010;
  localparam logic [2:0] OP_EOI_LVL  = 3'b011;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NUM = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] req_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] irr_o
);
  logic [NUM-1:0] prev_q;
  logic [NUM-1:0] irr_q;

  // R2: set on a rising edge; a new edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= req_i;
      irr_q  <= (irr_q & ~clr_i) | (req_i & ~prev_q);
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM = 8
) (
  input  logic [NUM-1:0]         vec_i,
  input  logic [$clog2(NUM)-1:0] top_i,
  output logic                   found_o,
  output logic [$clog2(NUM)-1:0] rank_o,
  output logic [$clog2(NUM)-1:0] lvl_o
);
  localparam int LW = $clog2(NUM);

  logic [LW-1:0] idx;

  // Scan from the lowest rank down so that the best rank is written last
  always_comb begin
    found_o = 1'b0;
    rank_o  = '0;
    lvl_o   = '0;
    idx     = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      idx = top_i + LW'(i);
      if (vec_i[idx]) begin
        found_o = 1'b1;
        rank_o  = LW'(i);
        lvl_o   = idx;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM = 8,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NUM-1:0] req_i,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          intr_valid,
  input  logic          intr_ready,
  output logic [DW-1:0] intr_vector,
  input  logic          poll_rd,
  output logic [DW-1:0] poll_data,
  output logic [NUM-1:0] in_service
);
  localparam int LW = $clog2(NUM);
  localparam logic [LW-1:0] LOW_RESET = LW'(NUM - 1);

  // Software state
  logic [NUM-1:0] mask_q;
  irq_mode_e      mode_q;
  logic [LW-1:0]  low_q;
  logic [DW-1:0]  base_q;
  logic [NUM-1:0] isr_q;

  // Decoded writes
  logic          wr_cmd;
  logic [2:0]    cmd_op;
  logic [LW-1:0] cmd_lvl;
  logic          eoi_top, eoi_lvl, set_low;

  assign wr_cmd  = wr_en && (wr_addr == ADDR_CMD);
  assign cmd_op  = wr_data[DW-1 -: 3];
  assign cmd_lvl = wr_data[LW-1:0];
  assign eoi_top = wr_cmd && (cmd_op == OP_EOI_TOP);
  assign eoi_lvl = wr_cmd && (cmd_op == OP_EOI_LVL);
  assign set_low = wr_cmd && (cmd_op == OP_SET_LOW);

  // Request latching
  logic [NUM-1:0] irr;
  logic [NUM-1:0] clr_vec;
  logic [NUM-1:0] pend_vec;

  irq_req_latch #(.NUM(NUM)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .clr_i (clr_vec),
    .irr_o (irr)
  );

  assign pend_vec = irr & ~mask_q;

  // Priority ordering: highest level sits just above the lowest
  logic [LW-1:0] eff_low;
  logic [LW-1:0] top_lvl;

  assign eff_low = (mode_q == MODE_FIXED) ? LOW_RESET : low_q;
  assign top_lvl = eff_low + LW'(1);

  logic          pend_found, isr_found;
  logic [LW-1:0] pend_rank, isr_rank;
  logic [LW-1:0] pend_lvl, isr_lvl;

  irq_prio_pick #(.NUM(NUM)) u_pick_pend (
    .vec_i   (pend_vec),
    .top_i   (top_lvl),
    .found_o (pend_found),
    .rank_o  (pend_rank),
    .lvl_o   (pend_lvl)
  );

  irq_prio_pick #(.NUM(NUM)) u_pick_isr (
    .vec_i   (isr_q),
    .top_i   (top_lvl),
    .found_o (isr_found),
    .rank_o  (isr_rank),
    .lvl_o   (isr_lvl)
  );

  // Offer to the processor
  logic beats_isr;
  logic ack_fire, poll_fire, take;

  assign beats_isr   = !isr_found || (pend_rank < isr_rank);
  assign intr_valid  = (mode_q != MODE_POLL) && pend_found && beats_isr;
  assign intr_vector = base_q + DW'(pend_lvl);

  assign ack_fire  = intr_valid && intr_ready;
  assign poll_fire = poll_rd && (mode_q == MODE_POLL) && pend_found;
  assign take      = ack_fire || poll_fire;

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[pend_lvl] = 1'b1;
  end

  always_comb begin
    poll_data           = '0;
    poll_data[DW-1]     = pend_found;
    poll_data[LW-1:0]   = pend_lvl;
  end

  // Register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= MODE_FIXED;
      base_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_MASK: mask_q <= wr_data[NUM-1:0];
        ADDR_MODE: mode_q <= irq_mode_e'(wr_data[1:0]);
        ADDR_BASE: base_q <= wr_data;
        default: ;
      endcase
    end
  end

  // Lowest-priority pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q <= LOW_RESET;
    end else if (set_low) begin
      low_q <= cmd_lvl;
    end else if (eoi_top && isr_found && (mode_q == MODE_ROTATE)) begin
      low_q <= isr_lvl;
    end
  end

  // In-service set: clears first, then the taken level
  logic [NUM-1:0] isr_next;

  always_comb begin
    isr_next = isr_q;
    if (eoi_top && isr_found) isr_next[isr_lvl] = 1'b0;
    if (eoi_lvl)              isr_next[cmd_lvl] = 1'b0;
    if (take)                 isr_next[pend_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_next;
  end

  assign in_service = isr_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int NUM = 8,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [1:0]     wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic           intr_valid,
  input logic           intr_ready,
  input logic [DW-1:0]  intr_vector,
  input logic [DW-1:0]  base_q,
  input logic [NUM-1:0] pend_vec,
  input logic [NUM-1:0] isr_q,
  input irq_mode_e      mode_q
);
  logic eoi_top_wr;
  assign eoi_top_wr = wr_en && (wr_addr == ADDR_CMD) && (wr_data[DW-1 -: 3] == OP_EOI_TOP);

  assert_offer_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    intr_valid |-> (pend_vec != '0));

  assert_poll_line_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_POLL) |-> !intr_valid);

  assert_vector_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    intr_valid |-> ((intr_vector - base_q) < DW'(NUM)));

  assert_take_adds_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_valid && intr_ready && !wr_en) |=>
      ($countones(isr_q) == $past($countones(isr_q)) + 1));

  assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_top_wr && (isr_q != '0) && !(intr_valid && intr_ready)) |=>
      ($countones(isr_q) + 1 == $past($countones(isr_q))));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM(NUM), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .intr_valid  (intr_valid),
  .intr_ready  (intr_ready),
  .intr_vector (intr_vector),
  .base_q      (base_q),
  .pend_vec    (pend_vec),
  .isr_q       (isr_q),
  .mode_q      (mode_q)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_i;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       intr_valid;
  logic       intr_ready;
  logic [7:0] intr_vector;
  logic       poll_rd;
  logic [7:0] poll_data;
  logic [7:0] in_service;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .intr_valid(intr_valid), .intr_ready(intr_ready), .intr_vector(intr_vector),
    .poll_rd(poll_rd), .poll_data(poll_data), .in_service(in_service)
  );

  localparam logic [7:0] BASE = 8'h40;

  // {mask, request pattern, expect offer, expected level}, fixed mode
  localparam int NVEC = 8;
  localparam logic [19:0] VECS [NVEC] = '{
    {8'h00, 8'h01, 1'b1, 3'd0},
    {8'h00, 8'h80, 1'b1, 3'd7},
    {8'h00, 8'hA4, 1'b1, 3'd2},
    {8'h00, 8'hFF, 1'b1, 3'd0},
    {8'h01, 8'h03, 1'b1, 3'd1},
    {8'hFF, 8'hFF, 1'b0, 3'd0},
    {8'hF0, 8'h30, 1'b0, 3'd0},
    {8'h0F, 8'h18, 1'b1, 3'd4}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    intr_ready = 1'b0; poll_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] r);
    req_i = r;
    @(negedge clk);
    req_i = '0;
    @(negedge clk);
  endtask

  task automatic ack();
    intr_ready = 1'b1;
    @(negedge clk);
    intr_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 valid", {7'd0, intr_valid}, 8'h00);
    chk("R1 in_service", in_service, 8'h00);
    chk("R1 poll_data", poll_data, 8'h00);

    // R4 / R3 table in fixed mode
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr(2'd3, BASE);
      wr(2'd0, VECS[i][19:12]);
      pulse_req(VECS[i][11:4]);
      chk("R4 table valid", {7'd0, intr_valid}, {7'd0, VECS[i][3]});
      if (VECS[i][3]) chk("R4 table vector", intr_vector, BASE + {5'd0, VECS[i][2:0]});
    end

    // R2 held after the line drops
    do_reset();
    wr(2'd3, BASE);
    pulse_req(8'h08);
    chk("R2 valid", {7'd0, intr_valid}, 8'h01);
    chk("R2 vector", intr_vector, 8'h43);

    // R5 transfer
    ack();
    chk("R5 in_service", in_service, 8'h08);
    chk("R5 valid after take", {7'd0, intr_valid}, 8'h00);

    // R6 nesting
    pulse_req(8'h20);
    chk("R6 lower blocked", {7'd0, intr_valid}, 8'h00);
    pulse_req(8'h02);
    chk("R6 higher offered", intr_vector, 8'h41);
    chk("R6 higher valid", {7'd0, intr_valid}, 8'h01);
    ack();
    chk("R6 nested isr", in_service, 8'h0A);

    // R7 nonspecific end
    wr(2'd2, 8'h20);
    chk("R7 isr", in_service, 8'h08);
    chk("R7 still blocked", {7'd0, intr_valid}, 8'h00);

    // R11 named end
    wr(2'd2, 8'h63);
    chk("R11 isr", in_service, 8'h00);
    chk("R11 vector", intr_vector, 8'h45);

    // R3 mask then unmask
    wr(2'd0, 8'h20);
    chk("R3 masked", {7'd0, intr_valid}, 8'h00);
    wr(2'd0, 8'h00);
    chk("R3 unmasked", intr_vector, 8'h45);
    chk("R3 unmasked valid", {7'd0, intr_valid}, 8'h01);

    // R5 ready without valid
    do_reset();
    ack();
    chk("R5 idle ready", in_service, 8'h00);

    // R8 rotation
    do_reset();
    wr(2'd3, BASE);
    wr(2'd1, 8'h01);
    pulse_req(8'h01);
    ack();
    wr(2'd2, 8'h20);
    chk("R8 isr cleared", in_service, 8'h00);
    pulse_req(8'h81);
    chk("R8 rotated winner", intr_vector, 8'h47);

    // R9 specified lowest
    do_reset();
    wr(2'd3, BASE);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h43);
    pulse_req(8'h0C);
    chk("R9 winner", intr_vector, 8'h42);
    pulse_req(8'h10);
    chk("R9 top level", intr_vector, 8'h44);

    // R12 mode switch while pending
    wr(2'd1, 8'h00);
    chk("R12 fixed order", intr_vector, 8'h42);

    // R10 polled
    do_reset();
    wr(2'd1, 8'h03);
    pulse_req(8'h50);
    chk("R10 line low", {7'd0, intr_valid}, 8'h00);
    chk("R10 poll", poll_data, 8'h84);
    poll_rd = 1'b1;
    @(negedge clk);
    poll_rd = 1'b0;
    chk("R10 isr", in_service, 8'h10);
    chk("R10 next poll", poll_data, 8'h86);

    done = 1'b1;
    finish_run();
  end
endmodule